// File: doc/BRIEF.md
# UART Baud Divisor Search Engine

This block picks the clock settings for a UART baud generator. The reference clock is fixed at 24 MHz. When the block is started with a requested baud rate, it tries each oversampling ratio from 4 up to 32 in ascending order. For each ratio it computes the integer divisor nearest to the ideal value and measures how far the resulting rate lands from the request. It keeps the ratio and divisor pair with the smallest relative error.

All arithmetic is integer. The ideal divisor is CLK / (baud·osr), so the relative error |div − ideal| / ideal equals |div·osr·baud − CLK| / CLK. The denominator is the same for every candidate, so candidates are ranked by the integer distance |div·osr·baud − CLK| alone. The rounded divisor comes from a one-bit-per-cycle restoring divider that computes floor((2·CLK + m) / (2·m)), with m = baud·osr. A full search takes a little under a thousand cycles.

The result is given as a ratio, a divisor, and a packed word ready for a baud-control register. A one-cycle done pulse marks the end of each search.

Top module: `baud_div_search`

## Requirements
- R1: After reset: done_o = 0, bad_rate_o = 0, osr_o = 4, div_o = 1 and baud_reg_o = 0x03000001.
- R2: Ratios 4 to 32 are all evaluated. For each ratio the divisor candidate is the rounded quotient floor(CLK/(baud·osr) + 1/2). The reported osr_o always lies in 4..32.
- R3: The rounded divisor is clamped to 1..8191 before it is evaluated. A quotient of 0 becomes 1, and anything above 8191 becomes 8191.
- R4: The reported pair minimises |div·osr·baud − CLK|. A candidate whose error is equal to or lower than the best so far replaces it, so a tie goes to the larger ratio.
- R5: baud_reg_o holds osr_o − 1 in bits [28:24] and div_o in bits [12:0]. All other bits are zero.
- R6: done_o is high for exactly one cycle when the search completes, and osr_o, div_o and baud_reg_o are updated on that same edge. Between completions the outputs do not change.
- R7: A start with baud_i = 0 runs no search. On the next cycle it sets bad_rate_o and pulses done_o, and it leaves osr_o and div_o unchanged. The next start with a non-zero rate clears bad_rate_o.
- R8: A start pulse that arrives while a search is running, or in the cycle in which done_o is high, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a search |
| baud_i | input | 24 | Requested baud rate in Hz, sampled with start |
| osr_o | output | 6 | Chosen oversampling ratio (4..32) |
| div_o | output | 13 | Chosen baud divisor (1..8191) |
| baud_reg_o | output | 32 | Packed word: ratio − 1 in [28:24], divisor in [12:0] |
| done_o | output | 1 | One-cycle pulse at the end of a search or a rejection |
| bad_rate_o | output | 1 | High after a start with a zero baud rate |

## Verification
The in-RTL assertions check on every cycle that:
- the divisor stays inside 1..8191 and the ratio inside 4..32;
- done never lasts more than one cycle;
- the results do not move while the engine is idle;
- a zero-rate start raises the error flag and pulses done without changing the divisor.

Whether the chosen pair is actually the best is a different matter. That includes the exact rounding, the tie-break towards the larger ratio and the two clamps, and only the bench's chosen rates can show it. Those rates have exact zero-error ties, a near-miss, and extremes at both ends that drive the divisor into each clamp. The bench also shows that a second start during a search is ignored.

// File: rtl/baud_div_search.sv
module baud_div_search #(
  parameter int CLK_HZ  = 24_000_000,
  parameter int BAUD_W  = 24,
  parameter int OSR_MIN = 4,
  parameter int OSR_MAX = 32,
  parameter int DIV_W   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BAUD_W-1:0] baud_i,
  output logic [5:0]        osr_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [31:0]       baud_reg_o,
  output logic              done_o,
  output logic              bad_rate_o
);
  localparam int NUM_W   = BAUD_W + 8;
  localparam int PROD_W  = NUM_W + DIV_W;
  localparam int CNT_W   = $clog2(NUM_W + 1);
  localparam int DIV_MAX = (1 << DIV_W) - 1;
  localparam logic [NUM_W-1:0]  CLK2 = NUM_W'(2 * CLK_HZ);
  localparam logic [PROD_W-1:0] CLKP = PROD_W'(CLK_HZ);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_DIV, S_EVAL} state_t;
  state_t state;

  logic [BAUD_W-1:0] baud_q;
  logic [5:0]        osr_cur, best_osr;
  logic [DIV_W-1:0]  best_div;
  logic [PROD_W-1:0] best_err;
  logic [NUM_W-1:0]  m, num, quo;
  logic [NUM_W:0]    rem;
  logic [CNT_W-1:0]  bitcnt;

  logic              go;
  logic [NUM_W:0]    den, trial;
  logic [DIV_W-1:0]  qc;
  logic [PROD_W-1:0] prod, err;
  logic              better;
  logic [NUM_W-1:0]  m_next;

  assign go     = start && state == S_IDLE && !done_o;
  assign m_next = NUM_W'(baud_q) * NUM_W'(osr_cur);
  assign den    = {m, 1'b0};
  assign trial  = {rem[NUM_W-1:0], num[NUM_W-1]};
  assign qc     = (quo == '0) ? DIV_W'(1) :
                  (quo > NUM_W'(DIV_MAX)) ? DIV_W'(DIV_MAX) : quo[DIV_W-1:0];
  assign prod   = PROD_W'(qc) * PROD_W'(m);
  assign err    = (prod >= CLKP) ? prod - CLKP : CLKP - prod;
  assign better = err <= best_err;
  assign baud_reg_o = {3'b000, 5'(osr_o - 6'd1), 11'b0, div_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      baud_q     <= '0;
      osr_cur    <= 6'(OSR_MIN);
      best_osr   <= 6'(OSR_MIN);
      best_div   <= DIV_W'(1);
      best_err   <= '1;
      m          <= '0;
      num        <= '0;
      quo        <= '0;
      rem        <= '0;
      bitcnt     <= '0;
      osr_o      <= 6'(OSR_MIN);
      div_o      <= DIV_W'(1);
      done_o     <= 1'b0;
      bad_rate_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: if (go) begin
          if (baud_i == '0) begin
            bad_rate_o <= 1'b1;
            done_o     <= 1'b1;
          end else begin
            bad_rate_o <= 1'b0;
            baud_q     <= baud_i;
            osr_cur    <= 6'(OSR_MIN);
            best_osr   <= 6'(OSR_MIN);
            best_div   <= DIV_W'(1);
            best_err   <= '1;
            state      <= S_SETUP;
          end
        end
        S_SETUP: begin
          m      <= m_next;
          num    <= CLK2 + m_next;
          rem    <= '0;
          quo    <= '0;
          bitcnt <= CNT_W'(NUM_W);
          state  <= S_DIV;
        end
        S_DIV: begin
          if (trial >= den) begin
            rem <= trial - den;
            quo <= {quo[NUM_W-2:0], 1'b1};
          end else begin
            rem <= trial;
            quo <= {quo[NUM_W-2:0], 1'b0};
          end
          num    <= num << 1;
          bitcnt <= bitcnt - 1'b1;
          if (bitcnt == CNT_W'(1)) state <= S_EVAL;
        end
        S_EVAL: begin
          if (better) begin
            best_err <= err;
            best_osr <= osr_cur;
            best_div <= qc;
          end
          if (osr_cur == 6'(OSR_MAX)) begin
            osr_o  <= better ? osr_cur : best_osr;
            div_o  <= better ? qc : best_div;
            done_o <= 1'b1;
            state  <= S_IDLE;
          end else begin
            osr_cur <= osr_cur + 6'd1;
            state   <= S_SETUP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_div_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_o >= DIV_W'(1) && div_o <= DIV_W'(DIV_MAX));

  assert_osr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    osr_o >= 6'(OSR_MIN) && osr_o <= 6'(OSR_MAX));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !start) |=> ($stable(osr_o) && $stable(div_o)));

  assert_zero_rate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && baud_i == '0) |=> (bad_rate_o && done_o && $stable(div_o) && $stable(osr_o)));

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && start) |=> !bad_rate_o || $past(bad_rate_o));
endmodule

// File: tb/test_baud_div_search.sv
module test_baud_div_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] baud_i = '0;
  logic [5:0]  osr_o;
  logic [12:0] div_o;
  logic [31:0] baud_reg_o;
  logic        done_o, bad_rate_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  baud_div_search i_baud_div_search (
    .clk(clk), .rst_n(rst_n), .start(start), .baud_i(baud_i),
    .osr_o(osr_o), .div_o(div_o), .baud_reg_o(baud_reg_o),
    .done_o(done_o), .bad_rate_o(bad_rate_o));

  // {baud, expected packed word}; packed layout per R5
  localparam logic [63:0] VECS [0:5] = '{
    {32'd115200,   32'h19000008},  // R4 near miss, osr 26 div 8
    {32'd9600,     32'h18000064},  // R4 zero-error tie, osr 25 div 100
    {32'd1000000,  32'h17000001},  // R4 tie at largest ratio, osr 24 div 1
    {32'd3000000,  32'h07000001},  // R2 rounding, osr 8 div 1
    {32'd1,        32'h1F001FFF},  // R3 upper clamp, osr 32 div 8191
    {32'd16000000, 32'h03000001}   // R3 lower clamp, osr 4 div 1
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [23:0] b);
    @(negedge clk);
    baud_i = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (done_o !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) chk({tag, " watchdog"}, 32'd0, 32'd1);
  endtask

  task automatic check_result(input string tag, input logic [31:0] pk);
    chk({tag, " osr"}, 32'(osr_o), 32'(pk[28:24]) + 32'd1);
    chk({tag, " div"}, 32'(div_o), 32'(pk[12:0]));
    chk({tag, " R5 packed"}, baud_reg_o, pk);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done", 32'(done_o), 32'd0);
    chk("R1 bad_rate", 32'(bad_rate_o), 32'd0);
    check_result("R1 reset", 32'h03000001);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      pulse_start(VECS[i][55:32]);
      wait_done($sformatf("R4 vec%0d", i));
      check_result($sformatf("R4 vec%0d", i), VECS[i][31:0]);
      chk("R7 bad_rate low", 32'(bad_rate_o), 32'd0);
      @(negedge clk);
      chk("R6 done one cycle", 32'(done_o), 32'd0);
    end

    // R6: outputs hold while idle
    repeat (20) @(negedge clk);
    check_result("R6 hold", 32'h03000001);

    // R8: second start during a search is ignored
    pulse_start(24'd115200);
    repeat (5) @(negedge clk);
    pulse_start(24'd9600);
    wait_done("R8");
    check_result("R8 busy ignore", 32'h19000008);
    @(negedge clk);
    chk("R8 no second done", 32'(done_o), 32'd0);
    repeat (1200) @(negedge clk);
    check_result("R8 still", 32'h19000008);

    // R7: zero rate rejected, results kept, flag cleared later
    pulse_start(24'd0);
    chk("R7 done", 32'(done_o), 32'd1);
    chk("R7 bad_rate", 32'(bad_rate_o), 32'd1);
    check_result("R7 unchanged", 32'h19000008);
    @(negedge clk);
    chk("R7 done one cycle", 32'(done_o), 32'd0);
    pulse_start(24'd9600);
    chk("R7 cleared", 32'(bad_rate_o), 32'd0);
    wait_done("R7 rerun");
    check_result("R7 rerun", 32'h18000064);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule